// File: doc/BRIEF.md
# Eight-Bit Compare Timer with PWM Outputs

This block is an 8-bit timer that drives two output pins through compare channels and raises a masked interrupt. Its counter runs in one of two ways. In free-running mode it counts up from zero to 0xFF and wraps. In up/down mode it climbs to a top value, which is channel 0's compare value, and then descends to zero. The up/down mode gives symmetric, centre-aligned pulses whose period is set by the top value rather than by 0xFF.

Each channel compares its compare value against the counter. On a match it sets, clears or toggles its pin, or it runs one of two PWM modes. The pins are driven straight from flops, so they cannot glitch. Channel 0's compare value is double-buffered and takes effect only when the counter is at zero. Channel 1's value takes effect as soon as it is written. Three raw flags (overflow, channel 0, channel 1) are set whatever their masks are. A combined flag shows any flag whose mask is set. The interrupt request is a single-cycle pulse, gated by a global enable.

Software uses a write port and a combinational read port. Register map (address: contents):
- 0 control: bit0 = up/down mode, bit1 = overflow mask. Writing this register restarts the counter.
- 1 and 2 channel 0 and channel 1 setup: bits[2:0] = compare mode, bit3 = mask.
- 3 and 4 channel 0 and channel 1 compare value. A read of address 3 returns the value in effect, not the buffered one.
- 5 flags: bit0 = overflow, bit1 = channel 0, bit2 = channel 1, bit3 = combined masked flag (read only).
- 6 counter (read only).
- 7 reads zero.

Top module: `pwm_timer8`

## Requirements
- R1: After reset the counter, both compare values, all setup fields and all flags read 0, both pins are low and the interrupt request is low.
- R2: With up/down mode off, each clock in which the run enable is high and no control write occurs advances the counter by one, wrapping 0xFF to 0x00. The overflow flag (flags bit0) is set at the edge at which the counter steps to 0x00 from a nonzero value, in either mode. With the run enable low the counter holds.
- R3: With up/down mode on, the counter rises by one per running clock until it equals the channel 0 compare value in effect, then falls by one per clock to 0x00, then rises again. If the top value is 0 the counter stays at 0.
- R4: Compare modes 0, 1 and 2 set, clear and toggle the pin at the edge following a running clock in which the counter equals the channel's compare value. Modes 5 to 7 leave the pin unchanged. Pins change only on running clocks.
- R5: Mode 3 drives the pin high on a match whose next count step is upward and low on a match whose next step is downward. In free-running mode (every step upward) mode 3 also drives the pin low on a running clock at count 0x00, and a match takes priority. Mode 4 is the inverse of mode 3.
- R6: A write to address 3 is buffered. The value takes effect at a running clock at count 0x00, or at a control write, and the step taken in that clock still uses the old top. A write to address 4 takes effect at the next edge.
- R7: A channel's flag is set at the edge that follows a running clock in which it matches. In up/down mode, channel 0's flag is instead set together with the overflow flag at the step to 0x00, and not on its match.
- R8: Flags are set regardless of their masks. Flags bit3 reads 1 exactly when some flag and its mask are both 1 (masks: control bit1, setup bit3 of each channel).
- R9: Writing address 5 clears every flag whose data bit is 0 and leaves flags whose data bit is 1. A hardware set at the same edge wins over the clear.
- R10: The interrupt request is high for exactly one cycle. The pulse comes one edge after the combined masked flag rises, including a rise caused by enabling a mask on a flag that is already set. It appears only if the global interrupt enable was high at that edge.
- R11: A control write resets the counter to 0x00 with the next step upward, and suppresses counting in that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Timer runs while high |
| irq_en | input | 1 | Global timer interrupt enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data for rd_addr (combinational) |
| pwm_out | output | 2 | Channel pins, bit n = channel n |
| irq_req | output | 1 | One-cycle interrupt request pulse |

## Verification
The assertions check several rules on every cycle: the counter holds when it is not running, and it moves by one step at most in up/down mode. The overflow flag is always present when the counter lands on zero. A channel 1 compare write is in effect at the next edge, and the pins stay still on idle clocks. The interrupt pulse is always single and gated by the enable. Other behaviour only shows up in the bench's scenarios, because it needs exact cycle positions. These include PWM set and clear points on the rising and falling slopes, and the deferred load of channel 0's value at the zero turnaround. They also include channel 0's flag moving to zero in up/down mode, set-over-clear priority on the flags, and a request raised by enabling a mask on a flag that is already set.

// File: rtl/pwm8_pkg.sv
package pwm8_pkg;

    localparam int NUM_CH = 2;
    localparam int ADDR_W = 3;
    localparam int NFLAG  = NUM_CH + 1;

    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] A_CFG0  = 3'd1;
    localparam logic [ADDR_W-1:0] A_CMP0  = 3'd3;
    localparam logic [ADDR_W-1:0] A_FLAGS = 3'd5;
    localparam logic [ADDR_W-1:0] A_COUNT = 3'd6;

    typedef enum logic [2:0] {
        CMP_SET  = 3'd0,
        CMP_CLR  = 3'd1,
        CMP_TGL  = 3'd2,
        CMP_PWM  = 3'd3,
        CMP_PWMN = 3'd4,
        CMP_NOP5 = 3'd5,
        CMP_NOP6 = 3'd6,
        CMP_NOP7 = 3'd7
    } cmp_mode_e;

    typedef struct packed {
        logic      mask;
        cmp_mode_e mode;
    } ch_cfg_t;

    // Next pin value for one channel in a running clock.
    function automatic logic next_pin(cmp_mode_e mode, logic cur, logic hit,
                                      logic rising, logic at_zero, logic updown);
        logic res;
        res = cur;
        unique case (mode)
            CMP_SET:  if (hit) res = 1'b1;
            CMP_CLR:  if (hit) res = 1'b0;
            CMP_TGL:  if (hit) res = ~cur;
            CMP_PWM: begin
                if (hit)                   res = rising;
                else if (!updown && at_zero) res = 1'b0;
            end
            CMP_PWMN: begin
                if (hit)                   res = ~rising;
                else if (!updown && at_zero) res = 1'b1;
            end
            default:  res = cur;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/pwm_counter.sv
module pwm_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         restart,
    input  logic         updown,
    input  logic [W-1:0] top,
    output logic [W-1:0] cnt,
    output logic         rising,
    output logic         zero_evt
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] cnt_q, cnt_n;
    logic         dir_q, up_n;

    always_comb begin
        cnt_n = cnt_q;
        up_n  = 1'b1;
        if (!updown) begin
            cnt_n = cnt_q + ONE;
        end else if (cnt_q == '0) begin
            cnt_n = (top == '0) ? '0 : ONE;
        end else if (dir_q && (cnt_q < top)) begin
            cnt_n = cnt_q + ONE;
        end else begin
            cnt_n = cnt_q - ONE;
            up_n  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= '0;
            dir_q <= 1'b1;
        end else if (tick) begin
            cnt_q <= cnt_n;
            dir_q <= up_n;
        end
    end

    assign cnt      = cnt_q;
    assign rising   = up_n;
    assign zero_evt = tick && (cnt_q != '0) && (cnt_n == '0);

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm8_pkg::*;
#(
    parameter int W        = 8,
    parameter bit BUFFERED = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic [W-1:0] cnt,
    input  logic         rising,
    input  logic         zero_evt,
    input  logic         updown,
    input  logic         load,
    input  logic         cfg_wr,
    input  logic         cmp_wr,
    input  logic [W-1:0] wdata,
    output logic         pin,
    output logic         flag_evt,
    output ch_cfg_t      cfg,
    output logic [W-1:0] cmp_val
);
    ch_cfg_t      cfg_q;
    logic [W-1:0] act_q, pend_q;
    logic         pin_q, hit;

    assign hit = tick && (cnt == act_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            act_q  <= '0;
            pend_q <= '0;
        end else begin
            if (cfg_wr) cfg_q <= ch_cfg_t'(wdata[3:0]);
            if (BUFFERED) begin
                if (cmp_wr) pend_q <= wdata;
                if (load)   act_q  <= pend_q;
            end else begin
                if (cmp_wr) act_q  <= wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)       pin_q <= 1'b0;
        else if (tick) pin_q <= next_pin(cfg_q.mode, pin_q, hit, rising,
                                         cnt == '0, updown);
    end

    // Channel 0 reports the zero turnaround in up/down mode.
    assign flag_evt = (BUFFERED && updown) ? zero_evt : hit;
    assign pin      = pin_q;
    assign cfg      = cfg_q;
    assign cmp_val  = act_q;

endmodule

// File: rtl/pwm_irq.sv
module pwm_irq #(
    parameter int NF = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          gie,
    input  logic [NF-1:0] set_evt,
    input  logic [NF-1:0] masks,
    input  logic          clr_wr,
    input  logic [NF-1:0] clr_data,
    output logic [NF-1:0] flags,
    output logic          masked_any,
    output logic          irq
);
    logic [NF-1:0] flags_q, keep;
    logic          prev_q, irq_q;

    assign keep       = clr_wr ? clr_data : '1;
    assign masked_any = |(flags_q & masks);

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            prev_q  <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            flags_q <= (flags_q & keep) | set_evt;
            prev_q  <= masked_any;
            irq_q   <= gie && masked_any && !prev_q;
        end
    end

    assign flags = flags_q;
    assign irq   = irq_q;

endmodule

// File: rtl/pwm_timer8.sv
module pwm_timer8
    import pwm8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_en,
    input  logic              irq_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [W-1:0]      rd_data,
    output logic [NUM_CH-1:0] pwm_out,
    output logic              irq_req
);
    logic             ud_mode, ovf_mask, ctrl_wr, tick, cc0_load;
    logic [W-1:0]     cnt_q;
    logic             rising, zero_evt;
    logic [NUM_CH-1:0] ch_evt, ch_mask;
    ch_cfg_t          cfgs   [NUM_CH];
    logic [W-1:0]     cc_act [NUM_CH];
    logic [W-1:0]     cc1_act;
    logic [NFLAG-1:0] flags;
    logic             masked_any, ovf_flag;

    assign ctrl_wr  = wr_en && (wr_addr == A_CTRL);
    assign tick     = run_en && !ctrl_wr;
    assign cc0_load = ctrl_wr || (tick && (cnt_q == '0));

    always_ff @(posedge clk) begin
        if (rst) begin
            ud_mode  <= 1'b0;
            ovf_mask <= 1'b0;
        end else if (ctrl_wr) begin
            ud_mode  <= wr_data[0];
            ovf_mask <= wr_data[1];
        end
    end

    pwm_counter #(.W(W)) u_cnt (
        .clk(clk), .rst(rst), .tick(tick), .restart(ctrl_wr),
        .updown(ud_mode), .top(cc_act[0]), .cnt(cnt_q),
        .rising(rising), .zero_evt(zero_evt)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        localparam logic [ADDR_W-1:0] CFG_A = ADDR_W'(A_CFG0 + g);
        localparam logic [ADDR_W-1:0] CMP_A = ADDR_W'(A_CMP0 + g);
        pwm_channel #(.W(W), .BUFFERED(g == 0)) u_ch (
            .clk(clk), .rst(rst), .tick(tick), .cnt(cnt_q),
            .rising(rising), .zero_evt(zero_evt), .updown(ud_mode),
            .load(cc0_load),
            .cfg_wr(wr_en && (wr_addr == CFG_A)),
            .cmp_wr(wr_en && (wr_addr == CMP_A)),
            .wdata(wr_data),
            .pin(pwm_out[g]), .flag_evt(ch_evt[g]),
            .cfg(cfgs[g]), .cmp_val(cc_act[g])
        );
        assign ch_mask[g] = cfgs[g].mask;
    end

    pwm_irq #(.NF(NFLAG)) u_irq (
        .clk(clk), .rst(rst), .gie(irq_en),
        .set_evt({ch_evt, zero_evt}),
        .masks({ch_mask, ovf_mask}),
        .clr_wr(wr_en && (wr_addr == A_FLAGS)),
        .clr_data(wr_data[NFLAG-1:0]),
        .flags(flags), .masked_any(masked_any), .irq(irq_req)
    );

    assign cc1_act  = cc_act[1];
    assign ovf_flag = flags[0];

    always_comb begin
        rd_data = '0;
        if (rd_addr == A_CTRL)  rd_data = W'({ovf_mask, ud_mode});
        if (rd_addr == A_FLAGS) rd_data = W'({masked_any, flags});
        if (rd_addr == A_COUNT) rd_data = cnt_q;
        for (int i = 0; i < NUM_CH; i++) begin
            if (rd_addr == ADDR_W'(A_CFG0 + i)) rd_data = W'(cfgs[i]);
            if (rd_addr == ADDR_W'(A_CMP0 + i)) rd_data = cc_act[i];
        end
    end

endmodule

// File: rtl/pwm_timer8_chk.sv
module pwm_timer8_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         run_en,
    input logic         irq_en,
    input logic         wr_en,
    input logic [2:0]   wr_addr,
    input logic [W-1:0] wr_data,
    input logic [1:0]   pwm_out,
    input logic         irq_req,
    input logic [W-1:0] cnt_q,
    input logic         ctrl_wr,
    input logic         ud_mode,
    input logic [W-1:0] cc1_act,
    input logic         ovf_flag
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    assert_count_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!run_en && !ctrl_wr) |=> $stable(cnt_q));

    assert_ovf_on_zero_R2: assert property (@(posedge clk) disable iff (rst)
        ($past(run_en) && !$past(ctrl_wr) && ($past(cnt_q) != '0) && (cnt_q == '0))
        |-> ovf_flag);

    assert_ud_step_R3: assert property (@(posedge clk) disable iff (rst)
        (ud_mode && run_en && !ctrl_wr) |=>
        ((cnt_q == $past(cnt_q) + ONE) || (cnt_q == $past(cnt_q) - ONE) ||
         (cnt_q == $past(cnt_q))));

    assert_cmp1_now_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_addr == 3'd4)) |=> (cc1_act == $past(wr_data)));

    assert_pins_idle_R4: assert property (@(posedge clk) disable iff (rst)
        !(run_en && !ctrl_wr) |=> $stable(pwm_out));

    assert_irq_single_R10: assert property (@(posedge clk) disable iff (rst)
        irq_req |=> !irq_req);

    assert_irq_gated_R10: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> $past(irq_en));

endmodule

bind pwm_timer8 pwm_timer8_chk #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .run_en(run_en), .irq_en(irq_en),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pwm_out(pwm_out), .irq_req(irq_req), .cnt_q(cnt_q),
    .ctrl_wr(ctrl_wr), .ud_mode(ud_mode), .cc1_act(cc1_act),
    .ovf_flag(ovf_flag)
);

// File: tb/sim_pwm_timer8.sv
`timescale 1ns/100ps
module sim_pwm_timer8;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       run_en = 1'b0, irq_en = 1'b0, wr_en = 1'b0;
    logic [2:0] wr_addr = '0, rd_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [1:0] pwm_out;
    logic       irq_req;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    pwm_timer8 u0 (
        .clk(clk), .rst(rst), .run_en(run_en), .irq_en(irq_en),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .pwm_out(pwm_out),
        .irq_req(irq_req)
    );

    // {wr, waddr, wdata, raddr, expected}
    localparam logic [22:0] VEC [0:9] = '{
        {1'b1, 3'd0, 8'h00, 3'd0, 8'h00},
        {1'b1, 3'd1, 8'hF3, 3'd1, 8'h03},
        {1'b1, 3'd2, 8'h1C, 3'd2, 8'h0C},
        {1'b1, 3'd4, 8'h5A, 3'd4, 8'h5A},
        {1'b1, 3'd3, 8'h40, 3'd3, 8'h00},
        {1'b1, 3'd0, 8'h02, 3'd3, 8'h40},
        {1'b0, 3'd0, 8'h00, 3'd0, 8'h02},
        {1'b0, 3'd0, 8'h00, 3'd6, 8'h00},
        {1'b1, 3'd5, 8'hFF, 3'd5, 8'h00},
        {1'b0, 3'd0, 8'h00, 3'd7, 8'h00}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        rd_addr = a;
        #0.5;
        v = rd_data;
    endtask

    initial begin : watchdog
        #500000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [7:0] v;
        logic       o;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 pins", {6'd0, pwm_out}, 8'h00);
        chk("R1 irq", {7'd0, irq_req}, 8'h00);
        rd(3'd6, v); chk("R1 count", v, 8'h00);
        rd(3'd5, v); chk("R1 flags", v, 8'h00);
        rd(3'd3, v); chk("R1 cmp0", v, 8'h00);

        // Register vectors (R6 buffering, R9 clear, R11 load via control)
        foreach (VEC[i]) begin
            if (VEC[i][22]) wr(VEC[i][21:19], VEC[i][18:11]);
            else edges(1);
            rd(VEC[i][10:8], v);
            chk("R6 R9 regvec", v, VEC[i][7:0]);
        end

        // R2 R5 free-running with PWM modes (ch0 mode3 @0x40, ch1 mode4 @0x5A)
        wr(3'd0, 8'h00);
        run_en = 1'b1;
        for (int k = 1; k <= 257; k++) begin
            edges(1);
            if (k == 1)     begin chk("R5 ch1 set at zero", {7'd0, pwm_out[1]}, 8'h01);
                                  chk("R5 ch0 clr at zero", {7'd0, pwm_out[0]}, 8'h00); end
            if (k == 8'h40) chk("R5 ch0 before match", {7'd0, pwm_out[0]}, 8'h00);
            if (k == 8'h41) begin chk("R5 ch0 set on match", {7'd0, pwm_out[0]}, 8'h01);
                                  rd(3'd6, v); chk("R2 count", v, 8'h41); end
            if (k == 8'h5A) chk("R5 ch1 before match", {7'd0, pwm_out[1]}, 8'h01);
            if (k == 8'h5B) chk("R5 ch1 clr on match", {7'd0, pwm_out[1]}, 8'h00);
            if (k == 255)   begin rd(3'd6, v); chk("R2 count FF", v, 8'hFF);
                                  rd(3'd5, v); chk("R2 no ovf yet", v & 8'h01, 8'h00); end
            if (k == 256)   begin rd(3'd6, v); chk("R2 wrap", v, 8'h00);
                                  rd(3'd5, v); chk("R8 flags all", v, 8'h0F); end
            if (k == 257)   chk("R5 pins at wrap", {6'd0, pwm_out}, 8'h02);
        end
        run_en = 1'b0;
        rd(3'd6, v);
        edges(5);
        begin logic [7:0] w; rd(3'd6, w); chk("R2 hold", w, v); end
        wr(3'd0, 8'h00);
        rd(3'd6, v); chk("R11 restart", v, 8'h00);

        // R8 R10 mask enable on a set flag, R9 set wins
        wr(3'd2, 8'h04);
        wr(3'd5, 8'h00);
        wr(3'd0, 8'h00);
        run_en = 1'b1; edges(8'h5B); run_en = 1'b0;
        rd(3'd5, v); chk("R8 raw flags unmasked", v, 8'h06);
        chk("R10 no irq unmasked", {7'd0, irq_req}, 8'h00);
        irq_en = 1'b1;
        wr(3'd2, 8'h0C);
        chk("R10 irq delay", {7'd0, irq_req}, 8'h00);
        edges(1); chk("R10 irq pulse", {7'd0, irq_req}, 8'h01);
        edges(1); chk("R10 irq one cycle", {7'd0, irq_req}, 8'h00);
        wr(3'd2, 8'h04);
        irq_en = 1'b0;
        wr(3'd2, 8'h0C);
        edges(1); chk("R10 gated", {7'd0, irq_req}, 8'h00);
        edges(1); chk("R10 gated later", {7'd0, irq_req}, 8'h00);
        wr(3'd5, 8'h00);
        wr(3'd0, 8'h00);
        run_en = 1'b1; edges(8'h5A);
        wr(3'd5, 8'h00);
        run_en = 1'b0;
        rd(3'd5, v); chk("R9 set wins over clear", v, 8'h0C);
        wr(3'd5, 8'h04);
        rd(3'd5, v); chk("R9 keep bit with 1", v, 8'h0C);

        // R3 R7 R6 up/down, top 0x10, ch1 mode3 @8
        wr(3'd2, 8'h03);
        wr(3'd5, 8'h00);
        wr(3'd4, 8'h08);
        wr(3'd3, 8'h10);
        wr(3'd1, 8'h00);
        wr(3'd0, 8'h03);
        edges(1);
        irq_en = 1'b1;
        run_en = 1'b1;
        for (int k = 1; k <= 37; k++) begin
            if (k == 5) begin wr_en = 1'b1; wr_addr = 3'd3; wr_data = 8'h04; end
            edges(1);
            wr_en = 1'b0;
            if (k == 9)  chk("R5 ud up match", {7'd0, pwm_out[1]}, 8'h01);
            if (k == 16) begin rd(3'd6, v); chk("R3 top", v, 8'h10); end
            if (k == 17) begin rd(3'd6, v); chk("R3 turn down", v, 8'h0F); end
            if (k == 24) chk("R5 ud before down match", {7'd0, pwm_out[1]}, 8'h01);
            if (k == 25) chk("R5 ud down match", {7'd0, pwm_out[1]}, 8'h00);
            if (k == 31) begin rd(3'd5, v); chk("R7 no ch0 flag at top", v, 8'h04);
                               rd(3'd3, v); chk("R6 cmp0 still old", v, 8'h10); end
            if (k == 32) begin rd(3'd6, v); chk("R3 zero", v, 8'h00);
                               rd(3'd5, v); chk("R7 ch0 flag at zero", v, 8'h0F); end
            if (k == 33) begin rd(3'd3, v); chk("R6 cmp0 loaded", v, 8'h04);
                               chk("R10 ovf irq", {7'd0, irq_req}, 8'h01); end
            if (k == 34) chk("R10 ovf irq ends", {7'd0, irq_req}, 8'h00);
            if (k == 37) begin rd(3'd6, v); chk("R3 new top turn", v, 8'h03); end
        end
        run_en = 1'b0;
        irq_en = 1'b0;

        // R4 compare modes
        wr(3'd1, 8'h02);
        wr(3'd3, 8'h02);
        wr(3'd0, 8'h00);
        o = pwm_out[0];
        run_en = 1'b1; edges(3); run_en = 1'b0;
        chk("R4 toggle", {7'd0, pwm_out[0]}, {7'd0, ~o});
        run_en = 1'b1; edges(256); run_en = 1'b0;
        chk("R4 toggle back", {7'd0, pwm_out[0]}, {7'd0, o});
        wr(3'd2, 8'h00);
        wr(3'd4, 8'h03);
        wr(3'd0, 8'h00);
        run_en = 1'b1; edges(4); run_en = 1'b0;
        chk("R4 set", {7'd0, pwm_out[1]}, 8'h01);
        wr(3'd2, 8'h05);
        wr(3'd0, 8'h00);
        run_en = 1'b1; edges(256); run_en = 1'b0;
        chk("R4 mode5 no action", {7'd0, pwm_out[1]}, 8'h01);
        wr(3'd2, 8'h01);
        wr(3'd0, 8'h00);
        run_en = 1'b1; edges(4); run_en = 1'b0;
        chk("R4 clear", {7'd0, pwm_out[1]}, 8'h00);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule